// File: doc/BRIEF.md
# Fixed-Point Radix-2 Complex Butterfly

This block is the arithmetic core of a radix-2 decimation-in-time FFT pass. On each accepted cycle it takes two complex data words, `f` and `g`, and one complex twiddle factor `W`. It returns the pair `F = f + W·g` and `G = f − W·g`. A surrounding controller supplies the operands and the twiddles, which are read from an external cosine and sine table. That controller also handles addressing, memories and the ordering of passes.

Data words are signed 22-bit fixed point with 4 fractional bits (18 integer bits), and each word has separate real and imaginary parts. Twiddle parts are signed 16-bit values with 15 fractional bits. The sine part is supplied already carrying the sign the forward transform needs, so the block treats `W` simply as `cos + j·sin`. The wide products keep full precision through the add and subtract. Each result part is then rounded and clamped once, on its way back to 22 bits. A single valid bit travels through the three-stage pipeline next to the data.

Top module: `bfly_core`

## Requirements
- R1: When out_valid is high, sum_re/sum_im equal f + W·g for the operands accepted three cycles earlier, where W·g has real part g_re·cos − g_im·sin and imaginary part g_re·sin + g_im·cos.
- R2: When out_valid is high, dif_re/dif_im equal f − W·g for the same operands.
- R3: Each result part is computed exactly at full width, with the data value scaled by 2^15. It is then narrowed by adding 2^14 and shifting right arithmetically by 15 (round half up). For example, f = 0, g_re = 1, cos = 0x4000 gives sum_re = 1 and dif_re = 0, and g_re = −1 gives sum_re = 0 and dif_re = 1.
- R4: A rounded result above 2^21 − 1 is output as 0x1FFFFF. A rounded result below −2^21 is output as 0x200000 (−2^21). Results never wrap.
- R5: The real and imaginary parts of each output are rounded and saturated independently, so one part may saturate while the other is exact.
- R6: Twiddle inputs are two's-complement Q1.15: 0x7FFF stands for just under +1.0, 0x4000 for +0.5, 0x8000 for −1.0.
- R7: out_valid equals in_valid delayed by exactly three clock cycles, so a cycle with in_valid low gives a cycle with out_valid low three cycles later.
- R8: While rst is high, at the next clock edge out_valid and all four result outputs become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are accepted |
| f_re | input | 22 | Operand f, real part (Q18.4) |
| f_im | input | 22 | Operand f, imaginary part (Q18.4) |
| g_re | input | 22 | Operand g, real part (Q18.4) |
| g_im | input | 22 | Operand g, imaginary part (Q18.4) |
| w_cos | input | 16 | Twiddle real part (Q1.15) |
| w_sin | input | 16 | Twiddle imaginary part, signed (Q1.15) |
| out_valid | output | 1 | Results on this cycle are valid |
| sum_re | output | 22 | F real part |
| sum_im | output | 22 | F imaginary part |
| dif_re | output | 22 | G real part |
| dif_im | output | 22 | G imaginary part |

## Verification
The latency assertion assumes in_valid is a clean 0/1 level that is stable at each rising edge. It only looks back over edges that follow the release of rst. The bench meets this by driving all inputs on the falling edge. The zero-operand and zero-twiddle properties only hold when the operands of that cycle really are zero. The bench supplies such cycles as directed vectors, and the random stimulus also reaches the full signed range of both data and twiddles, including the 0x8000 twiddle code.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int DATA_W  = 22;
    localparam int FRAC_W  = 4;
    localparam int TW_W    = 16;
    localparam int TW_FRAC = TW_W - 1;
    localparam int PROD_W  = DATA_W + TW_W;
    localparam int ACC_W   = PROD_W + 2;
    localparam int LAT     = 3;

    typedef logic signed [DATA_W-1:0] dword_t;
    typedef logic signed [TW_W-1:0]   tword_t;
    typedef logic signed [PROD_W-1:0] pword_t;
    typedef logic signed [ACC_W-1:0]  aword_t;

    typedef struct packed {
        dword_t re;
        dword_t im;
    } cdata_t;

    typedef struct packed {
        tword_t c;
        tword_t s;
    } ctw_t;

    typedef struct packed {
        pword_t rc;
        pword_t is;
        pword_t rs;
        pword_t ic;
    } prod_t;

    typedef struct packed {
        aword_t re;
        aword_t im;
    } cacc_t;

    localparam aword_t HALF_LSB = aword_t'(1) <<< (TW_FRAC - 1);
    localparam aword_t SAT_HI   = (aword_t'(1) <<< (DATA_W - 1)) - aword_t'(1);
    localparam aword_t SAT_LO   = -(aword_t'(1) <<< (DATA_W - 1));

    function automatic dword_t round_sat(input aword_t v);
        aword_t r;
        r = (v + HALF_LSB) >>> TW_FRAC;
        if (r > SAT_HI)
            return dword_t'(SAT_HI);
        else if (r < SAT_LO)
            return dword_t'(SAT_LO);
        else
            return dword_t'(r);
    endfunction

    function automatic aword_t align_data(input dword_t d);
        return aword_t'(d) <<< TW_FRAC;
    endfunction

endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul
    import bfly_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  cdata_t f_in,
    input  cdata_t g_in,
    input  ctw_t   w_in,
    output logic   valid_q,
    output cdata_t f_q,
    output prod_t  p_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            f_q     <= '0;
            p_q     <= '0;
        end else begin
            valid_q <= in_valid;
            f_q     <= f_in;
            p_q.rc  <= pword_t'(g_in.re) * pword_t'(w_in.c);
            p_q.is  <= pword_t'(g_in.im) * pword_t'(w_in.s);
            p_q.rs  <= pword_t'(g_in.re) * pword_t'(w_in.s);
            p_q.ic  <= pword_t'(g_in.im) * pword_t'(w_in.c);
        end
    end

endmodule

// File: rtl/bfly_combine.sv
module bfly_combine
    import bfly_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid_in,
    input  cdata_t f_in,
    input  prod_t  p_in,
    output logic   valid_q,
    output cdata_t f_q,
    output cacc_t  t_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            f_q     <= '0;
            t_q     <= '0;
        end else begin
            valid_q <= valid_in;
            f_q     <= f_in;
            t_q.re  <= aword_t'(p_in.rc) - aword_t'(p_in.is);
            t_q.im  <= aword_t'(p_in.rs) + aword_t'(p_in.ic);
        end
    end

endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
    import bfly_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid_in,
    input  cdata_t f_in,
    input  cacc_t  t_in,
    output logic   valid_q,
    output cdata_t sum_q,
    output cdata_t dif_q
);

    aword_t fa_re, fa_im;
    aword_t s_re, s_im, d_re, d_im;

    always_comb begin
        fa_re = align_data(f_in.re);
        fa_im = align_data(f_in.im);
        s_re  = fa_re + t_in.re;
        s_im  = fa_im + t_in.im;
        d_re  = fa_re - t_in.re;
        d_im  = fa_im - t_in.im;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            sum_q   <= '0;
            dif_q   <= '0;
        end else begin
            valid_q  <= valid_in;
            sum_q.re <= round_sat(s_re);
            sum_q.im <= round_sat(s_im);
            dif_q.re <= round_sat(d_re);
            dif_q.im <= round_sat(d_im);
        end
    end

    // R2
    sum_eq_dif_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && t_in.re == '0 && t_in.im == '0) |=> (sum_q == dif_q));

endmodule

// File: rtl/bfly_core.sv
module bfly_core
    import bfly_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] f_re,
    input  logic signed [DATA_W-1:0] f_im,
    input  logic signed [DATA_W-1:0] g_re,
    input  logic signed [DATA_W-1:0] g_im,
    input  logic signed [TW_W-1:0]   w_cos,
    input  logic signed [TW_W-1:0]   w_sin,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] sum_re,
    output logic signed [DATA_W-1:0] sum_im,
    output logic signed [DATA_W-1:0] dif_re,
    output logic signed [DATA_W-1:0] dif_im
);

    cdata_t f_s0, g_s0;
    ctw_t   w_s0;
    logic   v_s1, v_s2;
    cdata_t f_s1, f_s2;
    prod_t  p_s1;
    cacc_t  t_s2;
    cdata_t sum_s3, dif_s3;

    assign f_s0 = '{re: f_re, im: f_im};
    assign g_s0 = '{re: g_re, im: g_im};
    assign w_s0 = '{c: w_cos, s: w_sin};

    bfly_cmul u_cmul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .f_in     (f_s0),
        .g_in     (g_s0),
        .w_in     (w_s0),
        .valid_q  (v_s1),
        .f_q      (f_s1),
        .p_q      (p_s1)
    );

    bfly_combine u_combine (
        .clk      (clk),
        .rst      (rst),
        .valid_in (v_s1),
        .f_in     (f_s1),
        .p_in     (p_s1),
        .valid_q  (v_s2),
        .f_q      (f_s2),
        .t_q      (t_s2)
    );

    bfly_addsub u_addsub (
        .clk      (clk),
        .rst      (rst),
        .valid_in (v_s2),
        .f_in     (f_s2),
        .t_in     (t_s2),
        .valid_q  (out_valid),
        .sum_q    (sum_s3),
        .dif_q    (dif_s3)
    );

    assign sum_re = sum_s3.re;
    assign sum_im = sum_s3.im;
    assign dif_re = dif_s3.re;
    assign dif_im = dif_s3.im;

    // Edges seen since reset release, saturating at the pipeline depth.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'(LAT))
            since_rst <= since_rst + 2'd1;
    end

    // R7
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'(LAT)) |-> (out_valid == $past(in_valid, 3)));

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && sum_re == '0 && sum_im == '0 &&
                 dif_re == '0 && dif_im == '0));

    // R1
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && f_re == '0 && f_im == '0 && g_re == '0 && g_im == '0)
        |-> ##3 (out_valid && sum_re == '0 && sum_im == '0 &&
                 dif_re == '0 && dif_im == '0));

endmodule

// File: tb/bfly_core_bench.sv
`timescale 1ns/1ps
module bfly_core_bench;

    localparam longint DMAX = (64'sd1 <<< 21) - 1;
    localparam longint DMIN = -(64'sd1 <<< 21);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [21:0] f_re = '0, f_im = '0, g_re = '0, g_im = '0;
    logic signed [15:0] w_cos = '0, w_sin = '0;
    logic out_valid;
    logic signed [21:0] sum_re, sum_im, dif_re, dif_im;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit     v;
        longint sr, si, dr, di;
        string  tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    bfly_core u_bfly_core (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .f_re(f_re), .f_im(f_im), .g_re(g_re), .g_im(g_im),
        .w_cos(w_cos), .w_sin(w_sin),
        .out_valid(out_valid),
        .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im)
    );

    function automatic longint rnd_sat(input longint v);
        longint r;
        r = (v + 64'sd16384) >>> 15;
        if (r > DMAX) r = DMAX;
        if (r < DMIN) r = DMIN;
        return r;
    endfunction

    task automatic chk(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (exp_q.size() == 3) begin
            e = exp_q.pop_front();
            chk({"R7 out_valid ", e.tag}, longint'(out_valid), longint'(e.v));
            if (e.v) begin
                chk({"R1 sum_re ", e.tag}, longint'(sum_re), e.sr);
                chk({"R1 sum_im ", e.tag}, longint'(sum_im), e.si);
                chk({"R2 dif_re ", e.tag}, longint'(dif_re), e.dr);
                chk({"R2 dif_im ", e.tag}, longint'(dif_im), e.di);
            end
        end
    endtask

    task automatic drive(input bit v, input longint fr, input longint fi,
                         input longint gr, input longint gi,
                         input longint c, input longint s, input string tag);
        exp_t e;
        longint tr, ti;
        @(negedge clk);
        compare_out();
        in_valid = v;
        f_re = 22'(fr); f_im = 22'(fi);
        g_re = 22'(gr); g_im = 22'(gi);
        w_cos = 16'(c); w_sin = 16'(s);
        tr = gr * c - gi * s;
        ti = gr * s + gi * c;
        e.v = v;
        e.sr = rnd_sat((fr <<< 15) + tr);
        e.si = rnd_sat((fi <<< 15) + ti);
        e.dr = rnd_sat((fr <<< 15) - tr);
        e.di = rnd_sat((fi <<< 15) - ti);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R8: reset clears valid and all results
        chk("R8 out_valid", longint'(out_valid), 0);
        chk("R8 sum_re", longint'(sum_re), 0);
        chk("R8 sum_im", longint'(sum_im), 0);
        chk("R8 dif_re", longint'(dif_re), 0);
        chk("R8 dif_im", longint'(dif_im), 0);
        exp_q.delete();
        rst = 1'b0;
    endtask

    function automatic longint rand_data();
        return longint'($signed(22'($urandom)));
    endfunction

    function automatic longint rand_tw();
        return longint'($signed(16'($urandom)));
    endfunction

    initial begin
        do_reset();
        // R1 R2 near-identity twiddle
        drive(1, 100, -50, 32, 16, 32767, 0, "unity");
        // R3 half-LSB rounding, positive and negative product
        drive(1, 0, 0, 1, 0, 16384, 0, "R3 half pos");
        drive(1, 0, 0, -1, 0, 16384, 0, "R3 half neg");
        drive(1, 3, -3, 1, -1, 16384, 16384, "R3 mixed");
        // R6 code 0x8000 is -1.0
        drive(1, 0, 0, 64, -32, -32768, 0, "R6 minus one");
        drive(1, 10, 20, 32, 64, 0, 16384, "R6 sine only");
        // R4 R5 saturation, one part at a time
        drive(1, DMAX, DMIN, DMAX, DMAX, 32767, 0, "R4 R5 pos sat");
        drive(1, DMIN, 0, DMAX, 0, 32767, 0, "R4 neg sat");
        drive(1, DMIN, DMAX, DMIN, DMIN, -32768, -32768, "R4 R5 corner");
        // R7 bubbles
        drive(0, 5, 5, 5, 5, 100, 100, "R7 bubble");
        drive(1, 0, 0, 0, 0, 1234, -4321, "R1 zero data");
        drive(0, 0, 0, 0, 0, 0, 0, "R7 bubble");
        for (int i = 0; i < 400; i++)
            drive(($urandom % 5) != 0, rand_data(), rand_data(), rand_data(),
                  rand_data(), rand_tw(), rand_tw(), "random");
        // R8 reset with a full pipeline
        do_reset();
        for (int i = 0; i < 100; i++)
            drive(1'b1, rand_data() >>> 6, rand_data() >>> 6, rand_data(),
                  rand_data(), rand_tw(), rand_tw(), "random small f");
        for (int i = 0; i < 3; i++)
            drive(0, 0, 0, 0, 0, 0, 0, "flush");
        @(negedge clk);
        compare_out();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule